// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Engine

This block is one DMA channel that executes a single descriptor. A descriptor carries a mode word, an item count, a source field, an operand address and a destination address. Each item the engine moves is one of three kinds. A copy reads the source address and writes the destination. An immediate store writes the source field itself as data. An add-then-store adds a source value to a word read from the operand address and writes the sum. The source value can be a memory word or the immediate.

A transfer request starts work. In single mode one request moves one item. In burst mode one request moves every remaining item back to back. All memory traffic goes through a request/acknowledge master port. When the count reaches zero, a one-cycle completion interrupt can be raised.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `busy`, `irq` and `mem_req` are low, and no memory access happens until a request arrives.
- R2: Mode bits [2:1] = 00 select copy: each item reads the source address and writes the same value to the destination. Mode bit 0 selects the item size: 0 = 8-bit (`mem_size` 0), 1 = 16-bit (`mem_size` 1). An 8-bit read uses only `mem_rdata[7:0]`.
- R3: Mode bits [2:1] = 01 select an immediate store. The written data is the low byte of the source field (8-bit) or its low 16 bits (16-bit). Upper bits of the field never reach `mem_wdata`, and no read is issued.
- R4: Mode bits [2:1] = 10 add the source-address word to the operand-address word. Mode bits [2:1] = 11 add the immediate (narrowed as in R3) to the operand-address word. The sum is written modulo 2^8 or 2^16 with no carry kept.
- R5: Mode bit 4 makes the destination advance after each item, and mode bit 3 does the same for the source. The step is 1 for 8-bit items and 2 for 16-bit items. In memory-plus-memory addition the operand address advances exactly when the source does. In the two immediate kinds, bit 3 has no effect.
- R6: A request with a count of zero causes no memory access, no `busy` and no `irq`.
- R7: With mode bit 5 = 0 (single), each accepted request moves exactly one item and lowers the count by one. After that the engine returns to idle.
- R8: With mode bit 5 = 1 (burst), one request moves all remaining items back to back, and `busy` does not drop between them.
- R9: Mode bit 6 enables the completion interrupt. `irq` pulses for one cycle, right after the write that brings the count to zero, and only if bit 6 is set.
- R10: `mem_req` holds its address, direction and write data until `mem_ack`. `busy` is high from request acceptance until the last write of the request is acknowledged, and requests arriving while busy are dropped.
- R11: A descriptor load (`desc_load`) while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_load | input | 1 | Load the descriptor fields (taken only when idle) |
| desc_mode | input | 7 | Mode word: [0] size, [2:1] kind, [3] source step, [4] destination step, [5] burst, [6] interrupt enable |
| desc_count | input | CW | Item count |
| desc_src | input | AW | Source address, or immediate data |
| desc_opr | input | AW | Operand address for addition |
| desc_dst | input | AW | Destination address |
| xfer_req | input | 1 | Transfer request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 0 = byte, 1 = 16-bit |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Request in progress |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong item counter shows at the ports within one request. Either the number of writes per burst differs from the loaded count, or a request after exhaustion still starts traffic. A pointer that steps wrongly, or an operand pointer that drifts from the source pointer, puts a bad address on `mem_addr` by the second item. Wrong operand capture or narrowing appears as a bad `mem_wdata` on the very next write. A misplaced interrupt shows up as an `irq` pulse on a request that was not the last, or as no pulse at all, two cycles after `busy` falls.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    K_COPY = 2'd0,
    K_IMM  = 2'd1,
    K_ADDM = 2'd2,
    K_ADDI = 2'd3
  } kind_e;

  typedef struct packed {
    logic  int_en;
    logic  burst;
    logic  dst_inc;
    logic  src_inc;
    kind_e kind;
    logic  wide;
  } mode_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RDSRC = 2'd1,
    S_RDOPR = 2'd2,
    S_WRDST = 2'd3
  } st_e;

  // keep only the bits that belong to the selected item size
  function automatic logic [DATA_W-1:0] f_narrow(input logic [DATA_W-1:0] v,
                                                 input logic wide);
    return wide ? v : {{(DATA_W-8){1'b0}}, v[7:0]};
  endfunction

  // wrapping addition, no carry
  function automatic logic [DATA_W-1:0] f_sum(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic wide);
    return f_narrow(a + b, wide);
  endfunction

  function automatic logic [1:0] f_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  // first access of an item for each kind
  function automatic st_e f_first(input kind_e k);
    case (k)
      K_COPY, K_ADDM: return S_RDSRC;
      K_ADDI:         return S_RDOPR;
      default:        return S_WRDST;
    endcase
  endfunction

  function automatic logic f_src_moves(input kind_e k);
    return (k == K_COPY) || (k == K_ADDM);
  endfunction
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic [1:0]    step,
  output logic [AW-1:0] ptr
);
  localparam int unsigned PAD = AW - 2;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= base;
    else if (adv)  ptr <= ptr + {{PAD{1'b0}}, step};
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  input  kind_e         kind,
  input  logic          burst,
  input  logic          int_en,
  input  logic          xfer_req,
  input  logic          mem_ack,
  output st_e           state,
  output logic          busy,
  output logic          item_done,
  output logic          irq
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  st_e           nxt;
  logic          last;

  assign busy      = (state != S_IDLE);
  assign item_done = (state == S_WRDST) && mem_ack;
  assign last      = (cnt_q == ONE);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (xfer_req && !load && (cnt_q != '0)) nxt = f_first(kind);
      S_RDSRC: if (mem_ack) nxt = (kind == K_ADDM) ? S_RDOPR : S_WRDST;
      S_RDOPR: if (mem_ack) nxt = S_WRDST;
      S_WRDST: if (mem_ack) nxt = (last || !burst) ? S_IDLE : f_first(kind);
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      state <= nxt;
      irq   <= item_done && last && int_en;
      if (load)           cnt_q <= cnt_in;
      else if (item_done) cnt_q <= cnt_q - ONE;
    end
  end

  // R6: an active request never runs on an exhausted count
  p_cnt_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
  // R7: single mode returns to idle after each item
  p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !burst) |=> !busy);
  // R8: a burst keeps going while items remain
  p_burst_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && burst && !last) |=> busy);
  // R9: interrupt only when enabled
  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_en);
  // R9: interrupt follows a completed write and an idle engine
  p_irq_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(item_done)));
endmodule

// File: rtl/dma_data.sv
module dma_data
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] imm,
  input  kind_e             kind,
  input  logic              wide,
  input  st_e               state,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] opr_val;
  logic [DATA_W-1:0] imm_n;

  assign imm_n = f_narrow(imm, wide);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_val <= '0;
      opr_val <= '0;
    end else if (mem_ack) begin
      if (state == S_RDSRC) src_val <= f_narrow(mem_rdata, wide);
      if (state == S_RDOPR) opr_val <= f_narrow(mem_rdata, wide);
    end
  end

  always_comb begin
    case (kind)
      K_COPY:  wdata = src_val;
      K_IMM:   wdata = imm_n;
      K_ADDM:  wdata = f_sum(src_val, opr_val, wide);
      default: wdata = f_sum(imm_n, opr_val, wide);
    endcase
  end

  // R3: byte items never carry upper data bits on a write
  p_wdata_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WRDST) && !wide) |-> (wdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_load,
  input  logic [6:0]        desc_mode,
  input  logic [CW-1:0]     desc_count,
  input  logic [AW-1:0]     desc_src,
  input  logic [AW-1:0]     desc_opr,
  input  logic [AW-1:0]     desc_dst,
  input  logic              xfer_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              irq
);
  localparam int unsigned NPTR = 3;
  localparam int unsigned P_SRC = 0;
  localparam int unsigned P_OPR = 1;
  localparam int unsigned P_DST = 2;

  mode_t   mode_q;
  st_e     state;
  logic    item_done;
  logic    load_ok;
  logic    src_adv, opr_adv, dst_adv;
  logic [1:0] step;

  logic [AW-1:0] base [NPTR];
  logic [AW-1:0] ptr  [NPTR];
  logic          adv  [NPTR];

  assign load_ok = desc_load && !busy;
  assign step    = f_step(mode_q.wide);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (load_ok) mode_q <= mode_t'(desc_mode);
  end

  // pointer advance events
  assign src_adv = item_done && mode_q.src_inc && f_src_moves(mode_q.kind);
  assign opr_adv = item_done && mode_q.src_inc && (mode_q.kind == K_ADDM);
  assign dst_adv = item_done && mode_q.dst_inc;

  assign base[P_SRC] = desc_src;
  assign base[P_OPR] = desc_opr;
  assign base[P_DST] = desc_dst;
  assign adv[P_SRC]  = src_adv;
  assign adv[P_OPR]  = opr_adv;
  assign adv[P_DST]  = dst_adv;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    dma_ptr #(.AW(AW)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_ok),
      .base (base[gi]),
      .adv  (adv[gi]),
      .step (step),
      .ptr  (ptr[gi])
    );
  end

  dma_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .cnt_in   (desc_count),
    .kind     (mode_q.kind),
    .burst    (mode_q.burst),
    .int_en   (mode_q.int_en),
    .xfer_req (xfer_req),
    .mem_ack  (mem_ack),
    .state    (state),
    .busy     (busy),
    .item_done(item_done),
    .irq      (irq)
  );

  // the immediate is held in the source pointer, which never steps for immediates
  dma_data u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm      (ptr[P_SRC][DATA_W-1:0]),
    .kind     (mode_q.kind),
    .wide     (mode_q.wide),
    .state    (state),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .wdata    (mem_wdata)
  );

  assign mem_req  = (state != S_IDLE);
  assign mem_we   = (state == S_WRDST);
  assign mem_size = mode_q.wide;

  always_comb begin
    case (state)
      S_RDSRC: mem_addr = ptr[P_SRC];
      S_RDOPR: mem_addr = ptr[P_OPR];
      S_WRDST: mem_addr = ptr[P_DST];
      default: mem_addr = '0;
    endcase
  end

  // R10: a pending access keeps its attributes until acknowledged
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R5: operand pointer moves in lockstep with the source pointer
  p_opr_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && (mode_q.kind == K_ADDM)) |=>
      ((ptr[P_OPR] - $past(ptr[P_OPR])) == (ptr[P_SRC] - $past(ptr[P_SRC]))));
  // R5: immediate kinds never move the source field
  p_src_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !f_src_moves(mode_q.kind)) |=> $stable(ptr[P_SRC]));
endmodule

// File: tb/dma_desc_engine_test.sv
module dma_desc_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          desc_load = 1'b0;
  logic [6:0]    desc_mode = '0;
  logic [CW-1:0] desc_count = '0;
  logic [AW-1:0] desc_src = '0, desc_opr = '0, desc_dst = '0;
  logic          xfer_req = 1'b0;
  logic          mem_req, mem_we, mem_size;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [15:0]   mem_rdata = '0;
  logic          busy, irq;

  dma_desc_engine #(.AW(AW), .CW(CW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]    mem [0:255];
  int            wait_cyc = 0, wcnt = 0, wr_n = 0, rd_n = 0, irq_n = 0;
  logic          busy_seen = 1'b0;
  logic [AW-1:0] wa [0:31];
  logic [15:0]   wd [0:31];
  logic          ws [0:31];
  int            n_chk = 0, n_fail = 0;

  // memory model: answers at the falling edge
  always @(negedge clk) begin : mem_model
    logic [7:0] a;
    a = mem_addr[7:0];
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt < wait_cyc) wcnt++;
      else begin
        wcnt = 0; mem_ack = 1'b1;
        if (mem_we) begin
          mem[a] = mem_wdata[7:0];
          if (mem_size) mem[a + 8'd1] = mem_wdata[15:8];
          if (wr_n < 32) begin wa[wr_n] = mem_addr; wd[wr_n] = mem_wdata; ws[wr_n] = mem_size; end
          wr_n++;
        end else begin
          mem_rdata = mem_size ? {mem[a + 8'd1], mem[a]} : {8'hEE, mem[a]};
          rd_n++;
        end
      end
    end
  end

  always @(posedge clk) if (rst_n) begin
    if (irq) irq_n++;
    if (busy) busy_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [15:0] rd16(input logic [7:0] a);
    return {mem[a + 8'd1], mem[a]};
  endfunction

  task automatic clr();
    wr_n = 0; rd_n = 0; irq_n = 0; busy_seen = 1'b0;
  endtask

  task automatic load_desc(input logic [6:0] m, input int c, input logic [AW-1:0] s,
                           input logic [AW-1:0] o, input logic [AW-1:0] d);
    @(negedge clk);
    desc_mode = m; desc_count = CW'(c); desc_src = s; desc_opr = o; desc_dst = d;
    desc_load = 1'b1;
    @(negedge clk);
    desc_load = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 1000) begin @(negedge clk); k++; end
    if (k >= 1000) chk("R10 busy never cleared", 1, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    repeat (3) @(negedge clk);
    chk("R1 no access before request", mem_req, 0);
  endtask

  // copy, byte, both pointers step, single mode, interrupt on
  task automatic t_copy_single();
    clr();
    load_desc(7'h58, 3, 24'h10, 24'h0, 24'h80);
    for (int i = 0; i < 3; i++) begin
      kick(); wait_idle();
      chk("R7 one write per request", wr_n, i + 1);
      chk("R2 copy addr", wa[i], 24'h80 + i);
      chk("R2 copy data", wd[i], {8'h00, mem[8'h10 + i]});
      chk("R2 byte size", ws[i], 0);
      chk("R9 irq only at count end", irq_n, (i == 2) ? 1 : 0);
    end
    clr(); kick(); wait_idle();
    chk("R6 exhausted count no write", wr_n, 0);
    chk("R6 exhausted count no busy", busy_seen, 0);
    chk("R6 exhausted count no irq", irq_n, 0);
  endtask

  task automatic t_immediate();
    clr();
    load_desc(7'h3A, 2, 24'hADBE5A, 24'h0, 24'hA0);
    kick(); wait_idle();
    chk("R8 burst writes", wr_n, 2);
    chk("R3 no reads", rd_n, 0);
    chk("R3 byte immediate", wd[0], 16'h005A);
    chk("R5 dst step 1", wa[1], 24'hA1);
    chk("R9 irq disabled", irq_n, 0);
    clr();
    load_desc(7'h2B, 3, 24'h34ABCD, 24'h0, 24'hB0);
    kick(); wait_idle();
    chk("R8 burst writes 16", wr_n, 3);
    chk("R3 halfword immediate", wd[2], 16'hABCD);
    chk("R5 dst fixed", wa[2], 24'hB0);
    chk("R2 halfword size", ws[2], 1);
  endtask

  task automatic t_add_mem();
    logic [15:0] e [0:2];
    mem[8'h20] = 8'hF0; mem[8'h21] = 8'hFF; mem[8'h30] = 8'h25; mem[8'h31] = 8'h00;
    for (int i = 0; i < 3; i++) e[i] = rd16(8'h20 + 8'(2*i)) + rd16(8'h30 + 8'(2*i));
    clr();
    load_desc(7'h7D, 3, 24'h20, 24'h30, 24'hC0);
    kick(); wait_idle();
    chk("R8 one request whole count", wr_n, 3);
    chk("R4 reads per item", rd_n, 6);
    chk("R4 wrap sum", wd[0], 16'h0015);
    for (int i = 1; i < 3; i++) begin
      chk("R4 sum with stepping operands", wd[i], e[i]);
      chk("R5 dst step 2", wa[i], 24'hC0 + 2*i);
    end
    chk("R9 irq enabled burst", irq_n, 1);
    clr();
    load_desc(7'h34, 2, 24'h20, 24'h30, 24'hC8);
    kick(); wait_idle();
    chk("R5 fixed source and operand", wd[1], 16'h0015);
    chk("R4 byte wrap", wd[0], 16'h0015);
  endtask

  task automatic t_add_imm();
    logic [7:0] e;
    e = 8'hC8 + mem[8'h12];
    clr();
    load_desc(7'h3E, 2, 24'hFFFFC8, 24'h12, 24'hD0);
    kick(); wait_idle();
    chk("R4 imm plus mem reads", rd_n, 2);
    chk("R4 imm plus mem sum", wd[0], {8'h00, e});
    chk("R5 source bit ignored, operand fixed", wd[1], {8'h00, e});
    chk("R5 dst step", wa[1], 24'hD1);
  endtask

  task automatic t_zero();
    clr();
    load_desc(7'h58, 0, 24'h10, 24'h0, 24'h90);
    kick(); wait_idle();
    chk("R6 zero count busy", busy_seen, 0);
    chk("R6 zero count writes", wr_n + rd_n, 0);
    chk("R6 zero count irq", irq_n, 0);
  endtask

  task automatic t_while_busy();
    wait_cyc = 3;
    clr();
    load_desc(7'h18, 3, 24'h50, 24'h0, 24'hE0);
    kick();
    chk("R10 busy after accept", busy, 1);
    repeat (2) @(negedge clk);
    kick();
    load_desc(7'h58, 9, 24'h60, 24'h0, 24'h70);
    wait_idle();
    chk("R10 request while busy dropped", wr_n, 1);
    chk("R10 slow write addr", wa[0], 24'hE0);
    kick(); wait_idle();
    chk("R11 load while busy ignored addr", wa[1], 24'hE1);
    chk("R11 load while busy ignored data", wd[1], {8'h00, mem[8'h51]});
    kick(); wait_idle();
    clr(); kick(); wait_idle();
    chk("R11 old count kept", wr_n, 0);
    chk("R11 old interrupt enable kept", irq_n, 0);
    wait_cyc = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired act 0 exp 1");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i*7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_single();
    t_immediate();
    t_add_mem();
    t_add_imm();
    t_zero();
    t_while_busy();
    summary();
    $finish;
  end
endmodule